// File: doc/BRIEF.md
# Gap-coded RFID downlink writer

This block builds the reader-field envelope that sends a command to a 125 kHz read/write transponder. The transponder tells bits apart by how long the field stays on between short field-off gaps, so the writer only has to switch one enable line at the right moments. All timing is counted in ticks of a free-running 1 MHz timebase. Eight ticks make one carrier period of 8 µs, and every duration is a whole number of carrier periods.

A write begins with a single-cycle start strobe. The strobe loads a bit vector and a bit count. The block switches the field off for a long start gap. It then sends the bits, most significant first: each bit is a field-on interval, short for a 0 and long for a 1, followed by a fixed off-gap. The on-times are trimmed and the gaps stretched to allow for the antenna's slow decay. After the last gap the field comes back on. The block holds it on through a settling interval of at least 300 µs so that a readback can follow, and then flags completion for one clock. While idle, the field stays on.

Top module: `gap_writer`

## Requirements
- R1: After reset and whenever idle, field_en is 1, busy is 0 and done is 0.
- R2: An accepted start switches the field off for 50 carrier periods (400 ticks) before the first bit.
- R3: A bit of value 0 is sent as field on for 18 carrier periods (144 ticks).
- R4: A bit of value 1 is sent as field on for 50 carrier periods (400 ticks).
- R5: Every bit's on-interval is followed by field off for 20 carrier periods (160 ticks).
- R6: After the last gap the field is on for a settling interval of 38 carrier periods (304 ticks). The write then ends with done high for exactly one clock, and the field stays on.
- R7: busy rises on the clock edge that accepts start. It falls on the edge that raises done, and done is high only on that cycle.
- R8: bit_count selects bits[bit_count-1:0], sent from index bit_count-1 down to index 0. Bits above that range are ignored. A count above 80 is treated as 80.
- R9: A start strobe while busy is ignored and leaves the running write and its timing unchanged.
- R10: Durations advance only on clock edges where tick is 1. The tick sampled on the edge that accepts start is not counted. With tick held high for the whole write, busy lasts exactly as many clocks as the frame has ticks.
- R11: A bit count of 0 produces the start gap followed directly by the settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 MHz timebase enable, one clock wide |
| start | input | 1 | Begin a write (taken only when idle) |
| bit_count | input | 7 | Number of bits to send |
| bits | input | 80 | Bit vector; bit bit_count-1 goes first |
| field_en | output | 1 | Reader field enable (1 = carrier on) |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-clock pulse when the write completes |

## Verification
busy is due on the first rising edge after start is seen high. Each field_en change is due on the rising edge that samples the last counted tick of the phase before it. done and the fall of busy are due on the edge that ends the settling phase. The bench's reference model advances on the same edge and keeps each phase's remaining tick count. All three outputs are compared with the model on the falling edge, half a cycle after any change. With tick held high, the busy length in clocks is also checked against the frame length worked out from the bits.

// File: rtl/gap_writer.sv
module gap_writer #(
  parameter int TICKS_PER_CYC = 8,
  parameter int START_CYC     = 50,
  parameter int GAP_CYC       = 20,
  parameter int ZERO_CYC      = 18,
  parameter int ONE_CYC       = 50,
  parameter int SETTLE_CYC    = 38,
  parameter int MAX_BITS      = 80,
  parameter int CW            = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  logic [CW-1:0]       bit_count,
  input  logic [MAX_BITS-1:0] bits,
  output logic                field_en,
  output logic                busy,
  output logic                done
);

  localparam int START_T  = START_CYC  * TICKS_PER_CYC;
  localparam int GAP_T    = GAP_CYC    * TICKS_PER_CYC;
  localparam int ZERO_T   = ZERO_CYC   * TICKS_PER_CYC;
  localparam int ONE_T    = ONE_CYC    * TICKS_PER_CYC;
  localparam int SETTLE_T = SETTLE_CYC * TICKS_PER_CYC;
  localparam int L1 = (START_T > GAP_T) ? START_T : GAP_T;
  localparam int L2 = (ZERO_T > ONE_T) ? ZERO_T : ONE_T;
  localparam int L3 = (L1 > L2) ? L1 : L2;
  localparam int LONGEST = (L3 > SETTLE_T) ? L3 : SETTLE_T;
  localparam int TW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] MAXB_C = CW'(MAX_BITS);

  typedef enum logic [2:0] {S_IDLE, S_SGAP, S_ON, S_WGAP, S_SETTLE} st_t;

  st_t                 state;
  logic [TW-1:0]       left;
  logic [CW-1:0]       rem;
  logic [MAX_BITS-1:0] sr;
  logic [CW-1:0]       n_eff;

  assign n_eff    = (bit_count > MAXB_C) ? MAXB_C : bit_count;
  assign busy     = (state != S_IDLE);
  assign field_en = !(state == S_SGAP || state == S_WGAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      left  <= '0;
      rem   <= '0;
      sr    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          state <= S_SGAP;
          left  <= TW'(START_T);
          sr    <= bits << (MAXB_C - n_eff);
          rem   <= n_eff;
        end
      end else if (tick) begin
        if (left != TW'(1)) begin
          left <= left - TW'(1);
        end else begin
          case (state)
            S_SGAP, S_WGAP: begin
              if (rem != '0) begin
                state <= S_ON;
                left  <= sr[MAX_BITS-1] ? TW'(ONE_T) : TW'(ZERO_T);
              end else begin
                state <= S_SETTLE;
                left  <= TW'(SETTLE_T);
              end
            end
            S_ON: begin
              state <= S_WGAP;
              left  <= TW'(GAP_T);
              rem   <= rem - CW'(1);
              sr    <= sr << 1;
            end
            default: begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          endcase
        end
      end
    end
  end

endmodule

module gap_writer_chk #(
  parameter int MAX_OFF_TICKS = 400
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic start,
  input logic field_en,
  input logic busy,
  input logic done
);

  int unsigned off_run;

  always_ff @(posedge clk) begin
    if (!rst_n)            off_run <= 0;
    else if (field_en)     off_run <= 0;
    else if (tick)         off_run <= off_run + 1;
  end

  p_idle_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> field_en);

  p_off_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    off_run <= MAX_OFF_TICKS);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy)));

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(field_en) && !done));

endmodule

bind gap_writer gap_writer_chk #(.MAX_OFF_TICKS(START_CYC * TICKS_PER_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
  .field_en(field_en), .busy(busy), .done(done)
);

// File: tb/gap_writer_bench.sv
module gap_writer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  bit_count = '0;
  logic [79:0] bits = '0;
  logic        field_en, busy, done;

  int errors = 0;
  int checks = 0;
  int tick_div = 1;
  int tick_ctr = 0;
  bit tick_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  gap_writer u_gap_writer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .bit_count(bit_count), .bits(bits),
    .field_en(field_en), .busy(busy), .done(done)
  );

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick_ctr <= (tick_ctr + 1 >= tick_div) ? 0 : tick_ctr + 1;
    if (tick_rand) tick <= lfsr[0] & lfsr[3];
    else           tick <= (tick_ctr == 0);
  end

  int q_lvl[$];
  int q_dur[$];
  int q_kind[$];
  bit m_busy = 0, m_done = 0, m_field = 1;
  int m_kind = 0;

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      q_lvl.delete(); q_dur.delete(); q_kind.delete();
      m_busy = 0;
    end else if (m_busy) begin
      if (tick) begin
        q_dur[0] = q_dur[0] - 1;
        if (q_dur[0] == 0) begin
          void'(q_lvl.pop_front()); void'(q_dur.pop_front()); void'(q_kind.pop_front());
          if (q_lvl.size() == 0) begin m_busy = 0; m_done = 1; end
        end
      end
    end else if (start) begin
      int n;
      n = (bit_count > 80) ? 80 : int'(bit_count);
      q_lvl.push_back(0); q_dur.push_back(400); q_kind.push_back(2);
      for (int i = n - 1; i >= 0; i--) begin
        q_lvl.push_back(1); q_dur.push_back(bits[i] ? 400 : 144); q_kind.push_back(bits[i] ? 4 : 3);
        q_lvl.push_back(0); q_dur.push_back(160); q_kind.push_back(5);
      end
      q_lvl.push_back(1); q_dur.push_back(304); q_kind.push_back(6);
      m_busy = 1;
    end
    m_field = m_busy ? (q_lvl[0] != 0) : 1'b1;
    m_kind  = m_busy ? q_kind[0] : 1;
  end

  int busy_clks = 0;
  int done_cnt = 0;

  always @(negedge clk) begin
    if (busy) busy_clks++;
    if (done) done_cnt++;
    if (cmp_on) begin
      checks += 3;
      if (field_en !== m_field) begin
        errors++;
        $display("FAIL R%0d field_en: actual=%b expected=%b t=%0t", m_kind, field_en, m_field, $time);
      end
      if (busy !== m_busy) begin
        errors++;
        $display("FAIL R7 busy: actual=%b expected=%b t=%0t", busy, m_busy, $time);
      end
      if (done !== m_done) begin
        errors++;
        $display("FAIL R6 done: actual=%b expected=%b t=%0t", done, m_done, $time);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_write(int n, logic [79:0] v, string req, bit len_chk, int intr_at);
    int ne, total;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    busy_clks = 0; done_cnt = 0;
    start = 1; bit_count = 7'(n); bits = v;
    @(negedge clk);
    start = 0; bits = ~v; bit_count = 7'(n + 3);
    if (intr_at > 0) begin
      repeat (intr_at) @(negedge clk);
      start = 1; bit_count = 7'd3; bits = '1;
      @(negedge clk);
      start = 0;
    end
    while (m_busy) @(negedge clk);
    @(negedge clk);
    check(done_cnt == 1, {req, " done pulses"}, done_cnt, 1);
    if (len_chk) begin
      ne = (n > 80) ? 80 : n;
      total = 400 + 304;
      for (int i = 0; i < ne; i++) total += (v[i] ? 400 : 144) + 160;
      check(busy_clks == total, {req, " busy length"}, busy_clks, total);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<%0d", wd, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(field_en === 1'b1, "R1 reset field_en", int'(field_en), 1);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    check(done === 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1;
    cmp_on = 1;
    repeat (10) @(negedge clk);
    check(field_en === 1'b1 && busy === 1'b0, "R1 idle", int'(busy), 0);

    tick_div = 1;
    run_write(8, 80'hA5, "R3 R4 R5 R8 mixed byte", 1, 0);
    run_write(1, 80'h0, "R3 single zero", 1, 0);
    run_write(1, 80'h1, "R4 single one", 1, 0);
    run_write(0, 80'hFFFF, "R11 zero count", 1, 0);
    run_write(70, {10'h3FF, 70'h2_DEAD_BEEF_0123_4567}, "R8 long frame", 1, 0);
    run_write(100, 80'hF0F0_1234_5678_9ABC_DEF0, "R8 clamp", 1, 0);
    run_write(6, 80'h2D, "R9 start while busy", 1, 700);
    check(field_en === 1'b1 && busy === 1'b0, "R6 field on after write", int'(field_en), 1);

    tick_div = 3;
    run_write(5, 80'h16, "R10 slow tick", 0, 0);
    tick_rand = 1;
    run_write(4, 80'h9, "R10 irregular tick", 0, 0);
    run_write(3, 80'h5, "R9 R10 busy start irregular", 0, 900);
    tick_rand = 0;
    repeat (20) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 final idle", int'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule